// File: doc/BRIEF.md
# Parallel-Port Receive FIFO Request Controller

This block decides when a 16-byte parallel-port data FIFO asks the host for service while it moves data toward the host. It drives a DMA request line and an interrupt pin. It also gives a one-cycle pulse that sets the software-visible service-interrupt bit. The FIFO storage, the peripheral-side handshake and the register decode are outside the block. It only sees the FIFO fill level, the DMA acknowledge, terminal count, the host read strobe, and the current values of the direction, DMA-enable, service-interrupt and threshold register fields.

In DMA mode, the request follows the FIFO fill level. A burst is cut off after 32 acknowledge cycles. The request then stays low until the acknowledge has been idle for a recovery interval of about 350 ns. A terminal count stops all requests until software has seen the service-interrupt bit set and has cleared it again.

With DMA disabled, the block runs as an interrupt source for programmed I/O. It raises the interrupt when enough bytes are waiting, and the threshold field sets how many.

Top module: `ppq_req_ctl`

## Requirements
- R1: `dma_req` is high when all of these hold: `rev_dir`=1 (FIFO toward host), `dma_en`=1, `svc_bit`=0 and `fifo_level`≥1, unless R3–R8 hold it low.
- R2: `dma_req` is low whenever `fifo_level`=0, and rises in the same cycle that one byte becomes present.
- R3: With `fifo_level`=1, a rising edge of `dma_ack` drops `dma_req` in that same cycle. The request stays low while the level remains 1.
- R4: With `fifo_level`=1 and `dma_ack` already held high (no rising edge), `host_rd`=1 drops `dma_req` in that cycle. The request stays low while the level remains 1.
- R5: `term_cnt`=1 together with `dma_ack`=1 pulses `svc_set`, drops `dma_req` in that cycle, and raises `irq` from the next cycle. `term_cnt` without `dma_ack` has no effect.
- R6: After a qualified terminal count, `dma_req` stays low until `svc_bit` has been 1 and is then cleared to 0. That interrupt clears on the cycle after `svc_bit` falls.
- R7: A burst holds at most 32 acknowledge cycles, counted on falling edges of `dma_ack`. `dma_req` falls in the cycle in which the 32nd falls.
- R8: After a capped burst, `dma_req` stays low until `dma_ack` has been low for 18 consecutive clocks at 50 MHz (about 350 ns). Any reassertion of `dma_ack` restarts the count.
- R9: With `rev_dir`=1, `dma_en`=0 and `svc_bit`=0, `irq` is high exactly when `fifo_level` ≥ 16 − `thr_fld`.
- R10: Any `thr_fld` value above 15 (such as 16) behaves exactly like 15, so one byte raises `irq`.
- R11: `svc_bit`=1 masks the threshold interrupt and all requests. `dma_en`=0 blocks requests. With `rev_dir`=0 the block raises neither output.
- R12: After synchronous reset, `dma_req`, `irq` and `svc_set` are low and no hold-off is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_level | input | 5 | Bytes currently in the FIFO (0..16) |
| dma_ack | input | 1 | DMA acknowledge, active high |
| term_cnt | input | 1 | DMA terminal count |
| host_rd | input | 1 | Host read strobe, active high |
| rev_dir | input | 1 | 1 = data flows from FIFO to host |
| dma_en | input | 1 | DMA enable register bit |
| svc_bit | input | 1 | Service-interrupt register bit |
| thr_fld | input | 5 | Interrupt threshold field |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt pin, level |
| svc_set | output | 1 | Pulse that sets the service-interrupt bit |

## Verification
The hardest state to reach is the recovery hold-off. It appears only after 32 full acknowledge cycles inside one unbroken burst. So the stimulus keeps the FIFO full and drives 32 acknowledge pulses back to back. Then, with the acknowledge idle, it samples the request on every clock to find the exact cycle it returns. A second capped burst then briefly reasserts the acknowledge during the hold-off, which shows that the idle count restarts from zero.

// File: rtl/ppq_req_ctl.sv
module ppq_req_ctl #(
  parameter int DEPTH     = 16,
  parameter int BURST_MAX = 32,
  parameter int CLK_MHZ   = 50,
  parameter int IDLE_NS   = 350
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(DEPTH+1)-1:0]   fifo_level,
  input  logic                         dma_ack,
  input  logic                         term_cnt,
  input  logic                         host_rd,
  input  logic                         rev_dir,
  input  logic                         dma_en,
  input  logic                         svc_bit,
  input  logic [$clog2(DEPTH+1)-1:0]   thr_fld,
  output logic                         dma_req,
  output logic                         irq,
  output logic                         svc_set
);
  localparam int CNT_W    = $clog2(DEPTH+1);
  localparam int BW       = $clog2(BURST_MAX+1);
  localparam int IDLE_CYC = (IDLE_NS*CLK_MHZ + 999) / 1000;
  localparam int IW       = $clog2(IDLE_CYC+1);

  logic          ack_q, svc_q, holdoff, tc_lock, tc_irq, last_hold;
  logic [BW-1:0] burst_cnt;
  logic [IW-1:0] idle_cnt;

  wire ack_rise = dma_ack & ~ack_q;
  wire ack_fall = ~dma_ack & ack_q;
  wire tc_now   = term_cnt & dma_ack;
  wire is_last  = fifo_level == CNT_W'(1);
  wire last_drop = is_last & (ack_rise | host_rd | last_hold);
  wire dma_ok   = rev_dir & dma_en & ~svc_bit;

  wire req_base = dma_ok & (fifo_level != '0) & ~holdoff & ~tc_lock
                & ~tc_now & ~last_drop;
  wire cap_hit  = req_base & ack_fall & (burst_cnt == BW'(BURST_MAX-1));

  wire [CNT_W-1:0] thr_eff = (thr_fld > CNT_W'(DEPTH-1)) ? CNT_W'(DEPTH-1) : thr_fld;
  wire [CNT_W:0]   need    = (CNT_W+1)'(DEPTH) - {1'b0, thr_eff};
  wire pio_irq = rev_dir & ~dma_en & ~svc_bit & ({1'b0, fifo_level} >= need);

  assign dma_req = req_base & ~cap_hit;
  assign irq     = tc_irq | pio_irq;
  assign svc_set = tc_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q     <= 1'b0;
      svc_q     <= 1'b0;
      holdoff   <= 1'b0;
      tc_lock   <= 1'b0;
      tc_irq    <= 1'b0;
      last_hold <= 1'b0;
      burst_cnt <= '0;
      idle_cnt  <= '0;
    end else begin
      ack_q     <= dma_ack;
      svc_q     <= svc_bit;
      last_hold <= is_last & (ack_rise | host_rd | last_hold);

      if (tc_now)       tc_lock <= 1'b1;
      else if (svc_bit) tc_lock <= 1'b0;

      if (tc_now)                tc_irq <= 1'b1;
      else if (svc_q & ~svc_bit) tc_irq <= 1'b0;

      if (!req_base)     burst_cnt <= '0;
      else if (ack_fall) burst_cnt <= burst_cnt + BW'(1);

      if (cap_hit) begin
        holdoff  <= 1'b1;
        idle_cnt <= IW'(1);
      end else if (holdoff) begin
        if (dma_ack)                            idle_cnt <= '0;
        else if (idle_cnt >= IW'(IDLE_CYC-1))   holdoff  <= 1'b0;
        else                                    idle_cnt <= idle_cnt + IW'(1);
      end
    end
  end
endmodule

// File: rtl/ppq_req_ctl_chk.sv
module ppq_req_ctl_chk #(
  parameter int DEPTH     = 16,
  parameter int BURST_MAX = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic                       dma_ack,
  input logic                       term_cnt,
  input logic                       rev_dir,
  input logic                       dma_en,
  input logic                       svc_bit,
  input logic                       dma_req,
  input logic                       irq
);
  localparam int CW = $clog2(BURST_MAX+2);
  logic          req_q, ack_q;
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
      seen  <= '0;
    end else begin
      req_q <= dma_req;
      ack_q <= dma_ack;
      if (!req_q && !dma_req)      seen <= '0;
      else if (ack_q && !dma_ack)  seen <= seen + CW'(1);
    end
  end

  // R2
  empty_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> fifo_level != '0);

  // R11
  gated_req_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (rev_dir && dma_en && !svc_bit));

  // R5
  tc_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (term_cnt && dma_ack) |=> (irq && !dma_req));

  // R7
  burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
    seen <= CW'(BURST_MAX));

  // R9
  full_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (rev_dir && !dma_en && !svc_bit && fifo_level >= ($clog2(DEPTH+1))'(DEPTH)) |-> irq);
endmodule

bind ppq_req_ctl ppq_req_ctl_chk #(.DEPTH(DEPTH), .BURST_MAX(BURST_MAX)) u_chk (
  .clk(clk), .rst(rst), .fifo_level(fifo_level), .dma_ack(dma_ack),
  .term_cnt(term_cnt), .rev_dir(rev_dir), .dma_en(dma_en), .svc_bit(svc_bit),
  .dma_req(dma_req), .irq(irq));

// File: tb/ppq_req_ctl_test.sv
module ppq_req_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] fifo_level = '0, thr_fld = '0;
  logic dma_ack = 0, term_cnt = 0, host_rd = 0, rev_dir = 0, dma_en = 0, svc_bit = 0;
  logic dma_req, irq, svc_set;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ppq_req_ctl uut (.clk(clk), .rst(rst), .fifo_level(fifo_level), .dma_ack(dma_ack),
    .term_cnt(term_cnt), .host_rd(host_rd), .rev_dir(rev_dir), .dma_en(dma_en),
    .svc_bit(svc_bit), .thr_fld(thr_fld), .dma_req(dma_req), .irq(irq), .svc_set(svc_set));

  // {level[14:10], dir[9], en[8], svc[7], thr[6:2], exp_req[1], exp_irq[0]}
  localparam logic [14:0] VEC [0:15] = '{
    {5'd0,  1'b1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0},
    {5'd1,  1'b1, 1'b1, 1'b0, 5'd0,  1'b1, 1'b0},
    {5'd16, 1'b1, 1'b1, 1'b0, 5'd0,  1'b1, 1'b0},
    {5'd5,  1'b1, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0},
    {5'd5,  1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0},
    {5'd16, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1},
    {5'd1,  1'b1, 1'b0, 1'b0, 5'd15, 1'b0, 1'b1},
    {5'd1,  1'b1, 1'b0, 1'b0, 5'd16, 1'b0, 1'b1},
    {5'd0,  1'b1, 1'b0, 1'b0, 5'd16, 1'b0, 1'b0},
    {5'd4,  1'b1, 1'b0, 1'b0, 5'd12, 1'b0, 1'b1},
    {5'd3,  1'b1, 1'b0, 1'b0, 5'd12, 1'b0, 1'b0},
    {5'd16, 1'b1, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0},
    {5'd8,  1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0},
    {5'd8,  1'b0, 1'b0, 1'b0, 5'd15, 1'b0, 1'b0},
    {5'd9,  1'b1, 1'b0, 1'b0, 5'd7,  1'b0, 1'b1},
    {5'd8,  1'b1, 1'b0, 1'b0, 5'd7,  1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ack_pulse();
    dma_ack = 1'b1; step(); step();
    dma_ack = 1'b0; #1;
  endtask

  task automatic recovery(input string tag);
    for (int i = 1; i <= 18; i++) begin
      step(); #1;
      chk(tag, dma_req, i == 18);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    fifo_level = 5'd8; rev_dir = 1; dma_en = 1; term_cnt = 1; dma_ack = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R12: outputs held low during reset
    chk("R12 req", dma_req, 1'b0);
    chk("R12 irq", irq, 1'b0);
    rst = 0; term_cnt = 0; dma_ack = 0; fifo_level = 0; rev_dir = 0; dma_en = 0;
    step(); #1;
    chk("R12 req after", dma_req, 1'b0);
    chk("R12 irq after", irq, 1'b0);

    // R1 R2 R9 R10 R11 table
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fifo_level = VEC[i][14:10]; rev_dir = VEC[i][9]; dma_en = VEC[i][8];
      svc_bit = VEC[i][7]; thr_fld = VEC[i][6:2];
      #1;
      chk($sformatf("R1/R2/R11 req row %0d", i), dma_req, VEC[i][1]);
      chk($sformatf("R9/R10/R11 irq row %0d", i), irq, VEC[i][0]);
    end

    // R3: last byte drops on acknowledge rise
    @(negedge clk);
    rev_dir = 1; dma_en = 1; svc_bit = 0; thr_fld = 0; fifo_level = 1; #1;
    chk("R2 one byte", dma_req, 1'b1);
    dma_ack = 1; #1;
    chk("R3 ack rise", dma_req, 1'b0);
    step(); #1;
    chk("R3 ack held", dma_req, 1'b0);
    dma_ack = 0; step(); #1;
    chk("R3 ack low still last", dma_req, 1'b0);
    fifo_level = 0; step();
    fifo_level = 1; #1;
    chk("R2 refill", dma_req, 1'b1);

    // R4: host read strobe with acknowledge held
    fifo_level = 2; dma_ack = 1; step();
    fifo_level = 1; #1;
    chk("R4 before strobe", dma_req, 1'b1);
    host_rd = 1; #1;
    chk("R4 strobe", dma_req, 1'b0);
    step(); host_rd = 0; #1;
    chk("R4 after strobe", dma_req, 1'b0);
    dma_ack = 0; fifo_level = 0; step();

    // R5 R6: terminal count
    fifo_level = 8; term_cnt = 1; #1;
    chk("R5 tc no ack svc_set", svc_set, 1'b0);
    chk("R5 tc no ack req", dma_req, 1'b1);
    dma_ack = 1; #1;
    chk("R5 svc_set", svc_set, 1'b1);
    chk("R5 req drop", dma_req, 1'b0);
    step();
    term_cnt = 0; dma_ack = 0; #1;
    chk("R6 lock before bit", dma_req, 1'b0);
    chk("R5 irq", irq, 1'b1);
    svc_bit = 1; step(); step(); #1;
    chk("R6 bit set req", dma_req, 1'b0);
    chk("R6 bit set irq", irq, 1'b1);
    svc_bit = 0; #1;
    chk("R6 resume", dma_req, 1'b1);
    step(); #1;
    chk("R6 irq cleared", irq, 1'b0);

    // R11: stop mid-transfer by service bit then clearing enable
    svc_bit = 1; step(); dma_en = 0; step(); svc_bit = 0; #1;
    chk("R11 dma off", dma_req, 1'b0);
    dma_en = 1; #1;
    chk("R11 dma back", dma_req, 1'b1);

    // R7 R8: burst cap and recovery
    fifo_level = 16; step();
    for (int p = 1; p <= 31; p++) begin
      ack_pulse();
      step();
    end
    chk("R7 after 31", dma_req, 1'b1);
    dma_ack = 1; step(); step();
    dma_ack = 0; #1;
    chk("R7 cap at 32", dma_req, 1'b0);
    recovery("R8 recovery");

    // R8: acknowledge glitch restarts idle count
    for (int p = 1; p <= 32; p++) begin
      ack_pulse();
      if (p < 32) step();
    end
    chk("R7 second cap", dma_req, 1'b0);
    repeat (5) step();
    dma_ack = 1; step();
    dma_ack = 0; #1;
    chk("R8 glitch", dma_req, 1'b0);
    recovery("R8 restart");

    // R12: reset clears pending hold-off
    for (int p = 1; p <= 32; p++) begin
      ack_pulse();
      if (p < 32) step();
    end
    rst = 1; step(); rst = 0; #1;
    chk("R12 holdoff cleared", dma_req, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule